// File: doc/BRIEF.md
# Power-of-Two Oversampling Averager

This block sits between a converter's result port and the result buffer of a conversion sequencer. When a sequence step begins, it asks for a fixed number of conversions from the same channel, one after another. It adds the results in a flip-flop accumulator. Once the last result has been added, it writes one averaged word. The number of conversions per step is 1, 2, 4, 8, 16, 32 or 64. The average is formed by dropping the low bits of the sum, so the block contains no divider.

A step begins with a one-cycle start pulse, which also captures the averaging setting. The block holds its request line high until every conversion the step needs has been accepted. Each step therefore takes as many conversion times as its averaging factor. Results are never combined across triggers. A new start discards any partial sum. One factor setting serves every sequence that uses the block.

Top module: `ovs_averager`

## Requirements
- R1: During and right after reset, `avg_valid_o` and `conv_req_o` are 0.
- R2: In the cycle after a `step_start_i` pulse, `conv_req_o` is 1. It stays 1 until 2^k samples have been accepted, where k is the captured factor code. A sample is accepted on a rising edge where `conv_req_o`=1, `smp_valid_i`=1 and `step_start_i`=0. A cycle with `smp_valid_i`=0 is simply skipped. In the cycle after the last accepted sample, `conv_req_o` is 0.
- R3: In the cycle after the last accepted sample of a step, `avg_valid_o` is 1. In the same cycle, `avg_data_o` equals the sum of that step's 2^k samples, shifted right by k bits and truncated to 12 bits. No step ever accepts more than 64 samples.
- R4: `avg_valid_o` is high for exactly one cycle per completed step.
- R5: The 3-bit code on `factor_i` selects 2^code samples per step: codes 0 to 6 give 1 to 64 samples. Code 7 behaves exactly like code 6.
- R6: `factor_i` is captured only on a start. Changing it while a step is in progress does not change that step's sample count or shift.
- R7: Samples offered while no step is in progress are ignored. They cause no output and do not affect the next step's result.
- R8: A start that arrives while a step is in progress abandons the partial sum. The new step's result contains only its own samples.
- R9: The accumulator is 18 bits wide. Sixty-four samples of 4095 produce an average of 4095, with no wrap.
- R10: With code 0, each step passes its single sample through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_start_i | input | 1 | One-cycle pulse that begins a step and captures `factor_i` |
| factor_i | input | 3 | Log2 of the averaging factor (7 is treated as 6) |
| smp_valid_i | input | 1 | Conversion result is valid this cycle |
| smp_data_i | input | 12 | Conversion result |
| conv_req_o | output | 1 | Request for further conversions in the current step |
| avg_valid_o | output | 1 | One-cycle strobe marking an averaged result |
| avg_data_o | output | 12 | Averaged result |

## Verification
The request line rises one edge after the start pulse. Each sample enters the sum on the edge that accepts it. The averaged result and its strobe are registered, so they appear one edge after the final accepted sample. The strobe falls again one edge later.

The bench drives inputs on falling edges and reads outputs on the next falling edge, which is half a cycle after the edge that updated them. It checks the strobe and the data in that first cycle after the last sample. It checks the strobe low again in the following cycle. Between those points it checks that no strobe appears before the step's sample count is reached, including when idle cycles are inserted between samples.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ovs_state_e;
endpackage

// File: rtl/ovs_ctrl.sv
module ovs_ctrl
  import ovs_pkg::*;
#(
  parameter int LOG_MAX = 6,
  localparam int SH_W  = $clog2(LOG_MAX + 1),
  localparam int CNT_W = LOG_MAX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [SH_W-1:0] code_i,
  input  logic            smp_valid_i,
  output logic            busy_o,
  output logic            take_o,
  output logic            last_o,
  output logic [SH_W-1:0] shift_o
);
  ovs_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [SH_W-1:0]  k_q, k_n;
  logic [SH_W-1:0]  code_sat;
  logic [CNT_W-1:0] lim;
  logic             take;
  logic             last;

  assign code_sat = (code_i > SH_W'(LOG_MAX)) ? SH_W'(LOG_MAX) : code_i;
  assign lim      = CNT_W'((1 << k_q) - 1);
  assign take     = (st_q == ST_RUN) && smp_valid_i && !start_i;
  assign last     = take && (cnt_q == lim);

  always_comb begin
    st_n = st_q;
    cnt_n = cnt_q;
    k_n = k_q;
    if (start_i) begin
      st_n  = ST_RUN;
      cnt_n = '0;
      k_n   = code_sat;
    end else if (take) begin
      if (last) begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      k_q   <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      k_q   <= k_n;
    end
  end

  assign busy_o  = (st_q == ST_RUN);
  assign take_o  = take;
  assign last_o  = last;
  assign shift_o = k_q;
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum #(
  parameter int DATA_W = 12,
  parameter int LOG_MAX = 6,
  localparam int ACC_W = DATA_W + LOG_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [ACC_W-1:0]  sum_o
);
  logic [ACC_W-1:0] acc_q, acc_n;
  logic [ACC_W-1:0] sum;

  assign sum = acc_q + ACC_W'(din_i);

  always_comb begin
    acc_n = acc_q;
    if (clear_i)     acc_n = '0;
    else if (last_i) acc_n = '0;
    else if (take_i) acc_n = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  assign sum_o = sum;
endmodule

// File: rtl/ovs_shift.sv
module ovs_shift #(
  parameter int DATA_W = 12,
  parameter int LOG_MAX = 6,
  localparam int ACC_W = DATA_W + LOG_MAX,
  localparam int SH_W  = $clog2(LOG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ACC_W-1:0]  sum_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] cand [LOG_MAX+1];
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] data_q, data_n;
  logic              valid_q;

  for (genvar g = 0; g <= LOG_MAX; g++) begin : g_tap
    assign cand[g] = sum_i[g +: DATA_W];
  end

  always_comb begin
    sel = cand[0];
    for (int j = 1; j <= LOG_MAX; j++) begin
      if (shift_i == SH_W'(j)) sel = cand[j];
    end
  end

  always_comb begin
    data_n = data_q;
    if (load_i) data_n = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= load_i;
      data_q  <= data_n;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/ovs_averager.sv
module ovs_averager #(
  parameter int DATA_W = 12,
  parameter int LOG_MAX = 6,
  localparam int ACC_W = DATA_W + LOG_MAX,
  localparam int SH_W  = $clog2(LOG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_start_i,
  input  logic [SH_W-1:0]   factor_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic              conv_req_o,
  output logic              avg_valid_o,
  output logic [DATA_W-1:0] avg_data_o
);
  logic             busy;
  logic             take;
  logic             last;
  logic [SH_W-1:0]  shift;
  logic [ACC_W-1:0] sum;

  ovs_ctrl #(.LOG_MAX(LOG_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(step_start_i), .code_i(factor_i),
    .smp_valid_i(smp_valid_i), .busy_o(busy), .take_o(take),
    .last_o(last), .shift_o(shift)
  );

  ovs_accum #(.DATA_W(DATA_W), .LOG_MAX(LOG_MAX)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear_i(step_start_i), .take_i(take),
    .last_i(last), .din_i(smp_data_i), .sum_o(sum)
  );

  ovs_shift #(.DATA_W(DATA_W), .LOG_MAX(LOG_MAX)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(last), .sum_i(sum),
    .shift_i(shift), .valid_o(avg_valid_o), .data_o(avg_data_o)
  );

  assign conv_req_o = busy;
endmodule

// File: rtl/ovs_averager_chk.sv
module ovs_averager_chk #(
  parameter int LOG_MAX = 6
) (
  input logic clk,
  input logic rst_n,
  input logic step_start_i,
  input logic smp_valid_i,
  input logic conv_req_o,
  input logic avg_valid_o
);
  logic [LOG_MAX+1:0] seen_q;
  logic               acc_ok;

  assign acc_ok = conv_req_o && smp_valid_i && !step_start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen_q <= '0;
    else if (step_start_i) seen_q <= '0;
    else if (acc_ok)       seen_q <= seen_q + 1'b1;
  end

  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    step_start_i |=> conv_req_o); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_o && !smp_valid_i && !step_start_i) |=> conv_req_o); // R2
  AST_VALID_ENDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid_o |-> !conv_req_o); // R3
  AST_STEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= (LOG_MAX+2)'(1 << LOG_MAX)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid_o |=> !avg_valid_o); // R4
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_req_o && !step_start_i) |=> !avg_valid_o); // R7
endmodule

bind ovs_averager ovs_averager_chk #(.LOG_MAX(LOG_MAX)) i_chk (
  .clk(clk), .rst_n(rst_n), .step_start_i(step_start_i),
  .smp_valid_i(smp_valid_i), .conv_req_o(conv_req_o), .avg_valid_o(avg_valid_o)
);

// File: tb/test_ovs_averager.sv
`timescale 1ns/1ps
module test_ovs_averager;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_start_i;
  logic [2:0]  factor_i;
  logic        smp_valid_i;
  logic [11:0] smp_data_i;
  logic        conv_req_o;
  logic        avg_valid_o;
  logic [11:0] avg_data_o;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ovs_averager i_ovs_averager (
    .clk(clk), .rst_n(rst_n), .step_start_i(step_start_i), .factor_i(factor_i),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .conv_req_o(conv_req_o),
    .avg_valid_o(avg_valid_o), .avg_data_o(avg_data_o)
  );

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pat(int mode, int i, int seed);
    case (mode)
      0: return 4095;
      1: return (i * 37 + seed) & 12'hfff;
      2: return (i % 2 == 1) ? 4095 : 0;
      default: return ((i * 1103 + seed * 97) ^ (i << 5)) & 12'hfff;
    endcase
  endfunction

  // start one step with code, optionally swap factor_i mid-step, feed samples
  task automatic run_step(int code, int alt_code, int mode, int seed, bit gaps);
    int k, n, i, sum;
    bit gapped;
    k = (code > 6) ? 6 : code;
    n = 1 << k;
    sum = 0;
    i = 0;
    gapped = 0;
    @(negedge clk);
    step_start_i = 1'b1; factor_i = 3'(code); smp_valid_i = 1'b0;
    @(negedge clk);
    step_start_i = 1'b0; factor_i = 3'(alt_code);
    check("R2 request after start", int'(conv_req_o), 1);
    while (i < n) begin
      if (gaps && (i % 3 == 1) && !gapped) begin
        smp_valid_i = 1'b0;
        gapped = 1;
      end else begin
        smp_data_i = 12'(pat(mode, i, seed));
        sum += pat(mode, i, seed);
        smp_valid_i = 1'b1;
        i++;
        gapped = 0;
      end
      @(negedge clk);
      if (i < n) begin
        check("R2 request held", int'(conv_req_o), 1);
        check("R3 no early result (R5/R6 count)", int'(avg_valid_o), 0);
      end
    end
    smp_valid_i = 1'b0;
    check("R3 result strobe", int'(avg_valid_o), 1);
    check("R3 averaged data", int'(avg_data_o), (sum >> k) & 12'hfff);
    check("R2 request drops", int'(conv_req_o), 0);
    @(negedge clk);
    check("R4 single-cycle strobe", int'(avg_valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_start_i = 1'b0; factor_i = '0;
    smp_valid_i = 1'b0; smp_data_i = '0;
    repeat (2) @(negedge clk);
    check("R1 reset strobe", int'(avg_valid_o), 0);
    check("R1 reset request", int'(conv_req_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobe after reset", int'(avg_valid_o), 0);
    check("R1 request after reset", int'(conv_req_o), 0);

    // R5 R9 R10: sweep every code and data pattern, with and without gaps
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 4; m++)
        run_step(c, c, m, c * 11 + m, (m % 2) == 1);

    // R10: pass-through of single samples
    for (int v = 0; v < 4096; v += 273) run_step(0, 0, 1, v, 0);

    // R9: full-scale 64 samples, code 6 and code 7
    run_step(6, 6, 0, 0, 0);
    run_step(7, 7, 0, 0, 1);

    // R6: factor changed mid-step has no effect on this step
    run_step(2, 5, 3, 5, 0);
    run_step(5, 0, 1, 9, 1);

    // R7: idle samples are ignored
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      smp_valid_i = 1'b1; smp_data_i = 12'hfff;
      @(negedge clk);
      smp_valid_i = 1'b0;
      check("R7 idle no strobe", int'(avg_valid_o), 0);
      check("R7 idle no request", int'(conv_req_o), 0);
    end
    run_step(1, 1, 2, 0, 0);

    // R8: restart abandons partial sum
    @(negedge clk);
    step_start_i = 1'b1; factor_i = 3'd3;
    @(negedge clk);
    step_start_i = 1'b0;
    for (int j = 0; j < 3; j++) begin
      smp_valid_i = 1'b1; smp_data_i = 12'hfff;
      @(negedge clk);
      check("R8 partial step no strobe", int'(avg_valid_o), 0);
    end
    smp_valid_i = 1'b0;
    run_step(2, 2, 2, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule